// File: doc/BRIEF.md
# Write-Triggered Interrupt Router

This block routes up to 24 interrupt sources to a single delivery channel. Each source owns one table entry with an 8-bit vector, a trigger mode (edge or level), a mask and an in-service flag. A source raises a request either through its dedicated input pin or by a bus write of its number to an assertion register, so peripherals can interrupt without extra wires. The highest-priority deliverable entry is offered on a request/vector output and is retired when the receiver accepts it.

Level-triggered entries set their in-service flag on delivery. They are not delivered again until an end-of-interrupt (EOI) write names their vector. A single EOI write clears the flag on every entry holding that vector at once. Software reaches the table through an index register and a 32-bit data window.

Top module: `irq_router`

## Requirements
- R1: After reset the index register reads 0, every entry's low dword reads 0x400 (masked, vector 0, edge, not in service), and reqValid is 0.
- R2: Offset 0x00 holds the index (bits 7:0) and offset 0x10 reads or writes the dword the index selects. Index 0 holds the ID 0x01000000, index 1 the version 0x00170011 (last entry number in bits 23:16), index 0x10+2n entry n's low dword and 0x11+2n its high dword. The low dword holds the vector in 7:0, the trigger in 8 (1 = level), the in-service flag in 9 (read-only) and the mask in 10. The high dword holds a destination byte in 31:24.
- R3: A write to offset 0x20 with busAllowed=1 and bits 4:0 below 24 makes that entry pending; bits 31:5 are ignored.
- R4: An assertion write with bits 4:0 of 24 to 31, or with busAllowed=0, changes nothing.
- R5: Reads of offsets 0x20 and 0x40 return 0.
- R6: A write to offset 0x40 compares bits 7:0 with every entry's vector and clears the in-service flag of all matching entries in the same cycle; other entries keep theirs.
- R7: reqValid is 1 when some entry is pending, unmasked and not a level entry in service. reqVector is then the vector of the lowest-numbered such entry.
- R8: Accepting a delivery (reqValid and reqAccept in one cycle) clears that entry's pending state. A level entry also sets its in-service flag and is held back until an EOI clears it.
- R9: A masked entry keeps its pending state and is delivered once unmasked.
- R10: An edge entry becomes pending on a rising edge of its pin. A level entry is pending in every cycle its pin is high.
- R11: An assertion write for an entry in the same cycle that entry's delivery is accepted leaves it pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 8 | Register byte offset |
| busWdata | input | 32 | Write data |
| busAllowed | input | 1 | Writer is permitted to raise interrupts |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| irqPin | input | 24 | Dedicated interrupt inputs |
| reqValid | output | 1 | A deliverable interrupt is offered |
| reqVector | output | 8 | Vector of the offered interrupt |
| reqAccept | input | 1 | Receiver takes the offered interrupt |

## Verification
Delivery acceptance and an assertion write can land on the same entry in the same cycle. That case decides whether a fresh request survives the retirement of the old one. The bench raises reqAccept and drives the assertion write for the offered entry in one cycle. It expects the same vector to stay offered afterwards. It also repeats the case with the write naming a different entry, and then expects that other entry's vector next.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  localparam int VEC_W = 8;

  localparam logic [7:0] OFS_INDEX  = 8'h00;
  localparam logic [7:0] OFS_WINDOW = 8'h10;
  localparam logic [7:0] OFS_ASSERT = 8'h20;
  localparam logic [7:0] OFS_EOI    = 8'h40;

  localparam logic [7:0] IDX_TABLE_BASE = 8'h10;

  typedef struct packed {
    logic             idxWr;
    logic             winWr;
    logic [7:0]       idxVal;
    logic [VEC_W-1:0] winVec;
    logic             winTrig;
    logic             winMask;
    logic [7:0]       winDest;
    logic             assertHit;
    logic [4:0]       assertIrq;
    logic             eoiHit;
    logic [VEC_W-1:0] eoiVec;
  } busStrobes_t;

endpackage

// File: rtl/irq_router_ctrl.sv
module irq_router_ctrl
  import irq_router_pkg::*;
#(
  parameter int NUM_ENTRIES = 24,
  parameter int ADDR_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  input  logic              busAllowed,
  output busStrobes_t       strobes
);

  logic irqInRange;
  logic unusedBits;

  assign irqInRange = int'(busWdata[4:0]) < NUM_ENTRIES;
  assign unusedBits = ^{busWdata[23:11], busWdata[9]};

  always_comb begin
    strobes           = '0;
    strobes.idxVal    = busWdata[7:0];
    strobes.winVec    = busWdata[VEC_W-1:0];
    strobes.winTrig   = busWdata[8];
    strobes.winMask   = busWdata[10];
    strobes.winDest   = busWdata[31:24];
    strobes.assertIrq = busWdata[4:0];
    strobes.eoiVec    = busWdata[VEC_W-1:0];
    if (busWr) begin
      strobes.idxWr     = (busAddr == ADDR_W'(OFS_INDEX));
      strobes.winWr     = (busAddr == ADDR_W'(OFS_WINDOW));
      strobes.assertHit = (busAddr == ADDR_W'(OFS_ASSERT)) && busAllowed && irqInRange;
      strobes.eoiHit    = (busAddr == ADDR_W'(OFS_EOI));
    end
  end

  // R4: an assertion strobe only for permitted writers naming a real entry
  p_irq_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.assertHit |-> (busAllowed && (int'(strobes.assertIrq) < NUM_ENTRIES)));

  // R2: bus write strobes are mutually exclusive
  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.idxWr, strobes.winWr, strobes.assertHit, strobes.eoiHit}));

endmodule

// File: rtl/irq_router_pick.sv
module irq_router_pick #(
  parameter int NUM_ENTRIES = 24,
  parameter int IDX_W       = 5
) (
  input  logic [NUM_ENTRIES-1:0] eligible,
  output logic                   anyValid,
  output logic [IDX_W-1:0]       pickIdx
);

  always_comb begin
    pickIdx = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (eligible[i]) pickIdx = IDX_W'(i);
    end
  end

  assign anyValid = |eligible;

endmodule

// File: rtl/irq_router_dp.sv
module irq_router_dp
  import irq_router_pkg::*;
#(
  parameter int          NUM_ENTRIES = 24,
  parameter int          ADDR_W      = 8,
  parameter logic [31:0] ID_VALUE    = 32'h0100_0000,
  parameter logic [7:0]  VER_CODE    = 8'h11
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  busStrobes_t            strobes,
  input  logic [ADDR_W-1:0]      busAddr,
  output logic [31:0]            busRdata,
  input  logic [NUM_ENTRIES-1:0] irqPin,
  output logic                   reqValid,
  output logic [VEC_W-1:0]       reqVector,
  input  logic                   reqAccept
);

  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
  localparam int WIN_SPAN = 2 * NUM_ENTRIES;
  localparam logic [31:0] VER_VALUE = {8'h00, 8'(NUM_ENTRIES - 1), 8'h00, VER_CODE};

  logic [7:0]       indexReg;
  logic [VEC_W-1:0] vecReg  [NUM_ENTRIES];
  logic [7:0]       destReg [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] trigReg, maskReg, inSvcReg, pendReg, pinPrev;

  logic [NUM_ENTRIES-1:0] pendSet, eligible, grantOne, eoiClr, winSel;
  logic [IDX_W-1:0] pickIdx;
  logic             fire;

  logic [7:0]       winOff;
  logic [IDX_W-1:0] winEntry;
  logic             winHigh, winInTable;
  logic [31:0]      winData;

  assign winOff     = indexReg - IDX_TABLE_BASE;
  assign winEntry   = winOff[IDX_W:1];
  assign winHigh    = winOff[0];
  assign winInTable = (indexReg >= IDX_TABLE_BASE) && (int'(winOff) < WIN_SPAN);

  irq_router_pick #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_pick (
    .eligible (eligible),
    .anyValid (reqValid),
    .pickIdx  (pickIdx)
  );

  assign reqVector = vecReg[pickIdx];
  assign fire      = reqValid && reqAccept;

  for (genvar gi = 0; gi < NUM_ENTRIES; gi++) begin : g_entry
    logic pinEvent;
    assign pinEvent     = trigReg[gi] ? irqPin[gi] : (irqPin[gi] && !pinPrev[gi]);
    assign pendSet[gi]  = pinEvent || (strobes.assertHit && (strobes.assertIrq == 5'(gi)));
    assign eligible[gi] = pendReg[gi] && !maskReg[gi] && !(trigReg[gi] && inSvcReg[gi]);
    assign grantOne[gi] = fire && (pickIdx == IDX_W'(gi));
    assign eoiClr[gi]   = strobes.eoiHit && (vecReg[gi] == strobes.eoiVec);
    assign winSel[gi]   = strobes.winWr && winInTable && (winEntry == IDX_W'(gi));

    // R3 / R11: an assertion write always leaves its entry pending
    p_assert_pend_r11: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.assertHit && (strobes.assertIrq == 5'(gi))) |=> pendReg[gi]);
    // R8: a level delivery marks the entry in service
    p_level_insvc_r8: assert property (@(posedge clk) disable iff (!rstN)
      (grantOne[gi] && trigReg[gi]) |=> inSvcReg[gi]);
    // R8: an edge delivery retires the request unless a new one arrives
    p_edge_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
      (grantOne[gi] && !trigReg[gi] && !pendSet[gi]) |=> !pendReg[gi]);
    // R6: a matching EOI clears the in-service flag
    p_eoi_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
      (eoiClr[gi] && !(grantOne[gi] && trigReg[gi])) |=> !inSvcReg[gi]);
    // R9: masked pending entries hold their request
    p_mask_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
      (maskReg[gi] && pendReg[gi]) |=> pendReg[gi]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      indexReg <= '0;
      trigReg  <= '0;
      maskReg  <= '1;
      inSvcReg <= '0;
      pendReg  <= '0;
      pinPrev  <= '0;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        vecReg[i]  <= '0;
        destReg[i] <= '0;
      end
    end else begin
      if (strobes.idxWr) indexReg <= strobes.idxVal;
      pinPrev <= irqPin;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        if (winSel[i]) begin
          if (winHigh) begin
            destReg[i] <= strobes.winDest;
          end else begin
            vecReg[i]  <= strobes.winVec;
            trigReg[i] <= strobes.winTrig;
            maskReg[i] <= strobes.winMask;
          end
        end
        if (eoiClr[i]) inSvcReg[i] <= 1'b0;
        if (grantOne[i] && trigReg[i]) inSvcReg[i] <= 1'b1;
        if (grantOne[i]) pendReg[i] <= 1'b0;
        if (pendSet[i]) pendReg[i] <= 1'b1;
      end
    end
  end

  always_comb begin
    winData = '0;
    if (indexReg == 8'h00) begin
      winData = ID_VALUE;
    end else if (indexReg == 8'h01) begin
      winData = VER_VALUE;
    end else if (winInTable) begin
      if (winHigh) winData = {destReg[winEntry], 24'h0};
      else winData = {21'h0, maskReg[winEntry], inSvcReg[winEntry],
                      trigReg[winEntry], vecReg[winEntry]};
    end
  end

  always_comb begin
    busRdata = '0;
    if (busAddr == ADDR_W'(OFS_INDEX)) busRdata = {24'h0, indexReg};
    else if (busAddr == ADDR_W'(OFS_WINDOW)) busRdata = winData;
  end

  // R7: the offered entry is pending and unmasked
  p_grant_unmasked_r7: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (pendReg[pickIdx] && !maskReg[pickIdx]));
  // R7: no lower-numbered entry is deliverable
  p_grant_lowest_r7: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> ((eligible & ~({NUM_ENTRIES{1'b1}} << pickIdx)) == '0));
  // R8: an in-service level entry is never offered
  p_level_blocked_r8: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> !(trigReg[pickIdx] && inSvcReg[pickIdx]));

endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NUM_ENTRIES = 24,
  parameter int ADDR_W      = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   busWr,
  input  logic [ADDR_W-1:0]      busAddr,
  input  logic [31:0]            busWdata,
  input  logic                   busAllowed,
  output logic [31:0]            busRdata,
  input  logic [NUM_ENTRIES-1:0] irqPin,
  output logic                   reqValid,
  output logic [VEC_W-1:0]       reqVector,
  input  logic                   reqAccept
);

  busStrobes_t strobes;

  irq_router_ctrl #(.NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busWr      (busWr),
    .busAddr    (busAddr),
    .busWdata   (busWdata),
    .busAllowed (busAllowed),
    .strobes    (strobes)
  );

  irq_router_dp #(.NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .busAddr   (busAddr),
    .busRdata  (busRdata),
    .irqPin    (irqPin),
    .reqValid  (reqValid),
    .reqVector (reqVector),
    .reqAccept (reqAccept)
  );

endmodule

// File: tb/irq_router_tb.sv
module irq_router_tb;

  localparam int N = 24;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic [7:0]  busAddr = 8'h00;
  logic [31:0] busWdata = '0;
  logic        busAllowed = 1'b0;
  logic [31:0] busRdata;
  logic [N-1:0] irqPin = '0;
  logic        reqValid;
  logic [7:0]  reqVector;
  logic        reqAccept = 1'b0;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  irq_router u_dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busAllowed(busAllowed), .busRdata(busRdata),
    .irqPin(irqPin), .reqValid(reqValid), .reqVector(reqVector),
    .reqAccept(reqAccept)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d, input logic al);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWdata = d; busAllowed = al;
    @(negedge clk);
    busWr = 1'b0; busAllowed = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic setEntry(input int n, input logic [7:0] vec, input logic lvl, input logic msk);
    busWrite(8'h00, 32'(8'h10 + 2 * n), 1'b0);
    busWrite(8'h10, {21'h0, msk, 1'b0, lvl, vec}, 1'b0);
  endtask

  task automatic readLow(input int n, output logic [31:0] d);
    busWrite(8'h00, 32'(8'h10 + 2 * n), 1'b0);
    busRead(8'h10, d);
  endtask

  task automatic accept();
    @(negedge clk);
    reqAccept = 1'b1;
    @(negedge clk);
    reqAccept = 1'b0;
  endtask

  task automatic expectReq(input string tag, input logic [7:0] vec);
    #1;
    chk(tag, {23'h0, reqValid, reqVector}, {23'h0, 1'b1, vec});
  endtask

  task automatic expectIdle(input string tag);
    #1;
    chk(tag, {31'h0, reqValid}, 32'h0);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    busRead(8'h00, d); chk("R1 index", d, 32'h0);
    expectIdle("R1 reqValid");
    for (int n = 0; n < N; n++) begin
      readLow(n, d); chk($sformatf("R1 entry %0d", n), d, 32'h400);
    end

    // R2: ID and version
    busWrite(8'h00, 32'h0, 1'b0); busRead(8'h10, d); chk("R2 id", d, 32'h0100_0000);
    busWrite(8'h00, 32'h1, 1'b0); busRead(8'h10, d); chk("R2 version", d, 32'h0017_0011);
    busRead(8'h00, d); chk("R2 index readback", d, 32'h1);

    // R2: program all entries, edge, unmasked, vector 0x20+n
    for (int n = 0; n < N; n++) setEntry(n, 8'(8'h20 + n), 1'b0, 1'b0);
    for (int n = 0; n < N; n++) begin
      readLow(n, d); chk($sformatf("R2 low %0d", n), d, 32'(8'h20 + n));
    end
    for (int n = 0; n < N; n += 7) begin
      busWrite(8'h00, 32'(8'h11 + 2 * n), 1'b0);
      busWrite(8'h10, {8'(8'hC0 + n), 24'hFFFFFF}, 1'b0);
      busRead(8'h10, d); chk($sformatf("R2 high %0d", n), d, {8'(8'hC0 + n), 24'h0});
    end
    expectIdle("R2 no request after programming");

    // R3 / R4 / R8: sweep every IRQ number with upper bits set
    for (int q = 0; q < 32; q++) begin
      busWrite(8'h20, 32'hFFFF_FFE0 | 32'(q), 1'b1);
      if (q < N) begin
        expectReq($sformatf("R3 irq %0d", q), 8'(8'h20 + q));
        accept();
        expectIdle($sformatf("R8 edge retire %0d", q));
      end else begin
        expectIdle($sformatf("R4 irq %0d ignored", q));
      end
    end
    busWrite(8'h20, 32'd5, 1'b0);
    expectIdle("R4 disallowed writer");

    // R5: write-only registers read zero
    busRead(8'h20, d); chk("R5 assert reg", d, 32'h0);
    busRead(8'h40, d); chk("R5 eoi reg", d, 32'h0);

    // R7: lowest entry first
    busWrite(8'h20, 32'd7, 1'b1);
    busWrite(8'h20, 32'd3, 1'b1);
    busWrite(8'h20, 32'd15, 1'b1);
    expectReq("R7 first", 8'h23); accept();
    expectReq("R7 second", 8'h27); accept();
    expectReq("R7 third", 8'h2F); accept();
    expectIdle("R7 drained");

    // R9: masked entry keeps pending
    setEntry(2, 8'h22, 1'b0, 1'b1);
    busWrite(8'h20, 32'd2, 1'b1);
    busWrite(8'h20, 32'd4, 1'b1);
    expectReq("R9 masked skipped", 8'h24); accept();
    expectIdle("R9 masked held back");
    setEntry(2, 8'h22, 1'b0, 1'b0);
    expectReq("R9 unmasked delivery", 8'h22); accept();
    expectIdle("R9 drained");

    // R6 / R8: level entries and shared-vector EOI
    setEntry(8, 8'h55, 1'b1, 1'b0);
    setEntry(9, 8'h55, 1'b1, 1'b0);
    setEntry(10, 8'h56, 1'b1, 1'b0);
    busWrite(8'h20, 32'd8, 1'b1);
    busWrite(8'h20, 32'd9, 1'b1);
    busWrite(8'h20, 32'd10, 1'b1);
    expectReq("R8 level 8", 8'h55); accept();
    expectReq("R8 level 9", 8'h55); accept();
    expectReq("R8 level 10", 8'h56); accept();
    expectIdle("R8 level drained");
    readLow(8, d); chk("R8 in service 8", d, 32'h355);
    readLow(10, d); chk("R8 in service 10", d, 32'h356);
    busWrite(8'h20, 32'd8, 1'b1);
    expectIdle("R8 in-service blocks");
    busWrite(8'h40, 32'hABCD_EF55, 1'b0);
    readLow(8, d); chk("R6 cleared 8", d, 32'h155);
    readLow(9, d); chk("R6 cleared 9", d, 32'h155);
    readLow(10, d); chk("R6 kept 10", d, 32'h356);
    expectReq("R8 redelivery after EOI", 8'h55); accept();
    busWrite(8'h40, 32'h55, 1'b0);
    busWrite(8'h40, 32'h56, 1'b0);
    expectIdle("R6 all clear");

    // R10: edge pin
    @(negedge clk); irqPin[12] = 1'b1;
    @(negedge clk);
    expectReq("R10 edge pin", 8'h2C); accept();
    repeat (2) @(negedge clk);
    expectIdle("R10 held pin no repeat");
    irqPin[12] = 1'b0;

    // R10: level pin
    setEntry(13, 8'h60, 1'b1, 1'b0);
    @(negedge clk); irqPin[13] = 1'b1;
    @(negedge clk);
    expectReq("R10 level pin", 8'h60); accept();
    expectIdle("R10 level blocked");
    irqPin[13] = 1'b0;
    busWrite(8'h40, 32'h60, 1'b0);
    expectReq("R10 level repend", 8'h60); accept();
    busWrite(8'h40, 32'h60, 1'b0);
    expectIdle("R10 level drained");

    // R11: accept and assertion write on the same entry
    busWrite(8'h20, 32'd5, 1'b1);
    expectReq("R11 setup", 8'h25);
    @(negedge clk);
    reqAccept = 1'b1; busWr = 1'b1; busAddr = 8'h20; busWdata = 32'd5; busAllowed = 1'b1;
    @(negedge clk);
    reqAccept = 1'b0; busWr = 1'b0; busAllowed = 1'b0;
    expectReq("R11 same entry kept", 8'h25);
    @(negedge clk);
    reqAccept = 1'b1; busWr = 1'b1; busAddr = 8'h20; busWdata = 32'd6; busAllowed = 1'b1;
    @(negedge clk);
    reqAccept = 1'b0; busWr = 1'b0; busAllowed = 1'b0;
    expectReq("R11 other entry next", 8'h26); accept();
    expectIdle("R11 drained");

    summary();
  end

endmodule